// File: doc/BRIEF.md
# Presettable Johnson Divide-by-N Counter

This block divides its input clock by any whole number from 2 to 10. It uses a five-stage twisted-ring (Johnson) shift register. Each rising clock edge moves every stage into the next one. The first stage is loaded from a feedback term, and a 4-bit modulus select chooses where that term is taken. For an even ratio the first stage takes the complement of one tap. For an odd ratio it takes the NAND of two neighbouring taps, which drops one ring state per turn.

Two asynchronous controls override the clock. A reset forces every stage output high. A preset loads the five parallel load bits onto the stage outputs in inverted form. If the active part of the ring holds a pattern that does not belong to the counting sequence, a guard steers it back within N clocks. The divided clock is the output of the last active stage.

Top module: `johnson_div_n`

## Requirements
- R1: While `rst` is high, all five bits of `q` and `div_out` are 1, immediately and without waiting for a clock edge.
- R2: While `pre` is high and `rst` is low, `q` equals the bitwise inverse of `load_val`, with bit i of `q` taken from bit i of `load_val`, immediately and without a clock edge.
- R3: When `rst` and `pre` are both high, `q` is all ones.
- R4: On each rising `clk` edge with neither `rst` nor `pre` high, `q[i]` takes the previous value of `q[i-1]` for i = 1 to 4.
- R5: For an even ratio N with an in-sequence window, `q[0]` takes the inverse of `q[N/2-1]` on each edge. Counting from reset, `div_out` then has period N and stays low for N/2 clocks per period.
- R6: For an odd ratio N with an in-sequence window, `q[0]` takes the NAND of `q[(N-1)/2-1]` and `q[(N-1)/2]`. `div_out` then has period N and stays low for (N-1)/2 clocks per period.
- R7: A `mod_sel` value from 2 to 10 selects that ratio; the values 0, 1 and 11 to 15 select ratio 10.
- R8: `div_out` always equals `q[k-1]`, where k = (N+1)/2 is the number of active stages.
- R9: The window `q[k-1:0]` is in sequence when, read with `q[0]` as bit 0, it equals 2^j-1 or (2^k-1)-(2^j-1) for some j in 0..k; for odd N the all-zero window is excluded. While the window is out of sequence, `q[0]` loads 1 on the next edge, and the window is back in sequence within N clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high; forces all stages high |
| pre | input | 1 | Asynchronous preset, active high; loads inverted `load_val` |
| load_val | input | 5 | Parallel load bits used by preset |
| mod_sel | input | 4 | Division ratio select |
| q | output | 5 | Stage outputs, `q[0]` is the first stage |
| div_out | output | 1 | Divided clock, output of the last active stage |

## Verification
The hardest case to reach is an out-of-sequence ring pattern. Reset and normal counting never produce one, so the guard that returns the ring to its sequence is otherwise never used. The stimulus reaches these patterns through the preset. Directed load values place alternating or split patterns in the active window for odd and even ratios. A seeded random series then pairs load values with raw select codes, including out-of-range codes. After each release the bench counts the clocks until the window is in sequence again, then measures the output period.

// File: rtl/jdiv_pkg.sv
`timescale 1ns/1ps
package jdiv_pkg;

  localparam int RING_LEN = 5;

  // Selected ratio: out-of-range codes fall back to the longest ring
  function automatic int ratio_of(int sel, int stages);
    if (sel < 2 || sel > 2 * stages) return 2 * stages;
    return sel;
  endfunction

  // Number of stages that take part in a given ratio
  function automatic int taps_of(int ratio);
    return (ratio + 1) / 2;
  endfunction

  // A window belongs to the count when it has at most one 0/1 boundary;
  // odd rings never hold the all-zero window
  function automatic bit window_ok(logic [31:0] v, int taps, bit odd);
    int edges;
    bit any_one;
    edges   = 0;
    any_one = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i < taps) begin
        any_one = any_one | v[i];
        if (i + 1 < taps && v[i] != v[i+1]) edges++;
      end
    end
    return (edges <= 1) && !(odd && !any_one);
  endfunction

endpackage

// File: rtl/jdiv_ratio_decode.sv
`timescale 1ns/1ps
module jdiv_ratio_decode #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4,
  parameter int RW     = 4,
  parameter int KW     = 3
) (
  input  logic [SEL_W-1:0] mod_sel,
  output logic [RW-1:0]    ratio,
  output logic [KW-1:0]    taps,
  output logic             odd
);

  int r_int;

  always_comb begin
    r_int = jdiv_pkg::ratio_of(int'(mod_sel), STAGES);
    ratio = RW'(r_int);
    taps  = KW'(jdiv_pkg::taps_of(r_int));
    odd   = r_int[0];
  end

endmodule

// File: rtl/jdiv_feedback.sv
`timescale 1ns/1ps
module jdiv_feedback #(
  parameter int STAGES = 5,
  parameter int KW     = 3
) (
  input  logic [STAGES-1:0] q,
  input  logic [KW-1:0]     taps,
  input  logic              odd,
  output logic              fb,
  output logic              illegal,
  output logic              tap_q
);

  logic        near_q;
  logic [31:0] q_wide;

  // Pick the last active stage and its left neighbour
  always_comb begin
    tap_q  = q[0];
    near_q = q[0];
    for (int i = 0; i < STAGES; i++) begin
      if (i + 1 == int'(taps)) tap_q  = q[i];
      if (i + 2 == int'(taps)) near_q = q[i];
    end
  end

  assign q_wide  = 32'(q);
  assign illegal = !jdiv_pkg::window_ok(q_wide, int'(taps), odd);

  // Guard: an out-of-sequence window shifts in ones until it is clean
  always_comb begin
    if (illegal)  fb = 1'b1;
    else if (odd) fb = ~(near_q & tap_q);
    else          fb = ~tap_q;
  end

endmodule

// File: rtl/jdiv_ring.sv
`timescale 1ns/1ps
module jdiv_ring #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre,
  input  logic [STAGES-1:0] load_val,
  input  logic              fb,
  output logic [STAGES-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    logic bit_q;
    if (i == 0) begin : g_head
      assign d = fb;
    end else begin : g_link
      assign d = q[i-1];
    end
    always_ff @(posedge clk or posedge rst or posedge pre) begin
      if (rst)      bit_q <= 1'b1;
      else if (pre) bit_q <= ~load_val[i];
      else          bit_q <= d;
    end
    assign q[i] = bit_q;
  end

endmodule

// File: rtl/johnson_div_n.sv
`timescale 1ns/1ps
module johnson_div_n #(
  parameter int STAGES = jdiv_pkg::RING_LEN,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre,
  input  logic [STAGES-1:0] load_val,
  input  logic [SEL_W-1:0]  mod_sel,
  output logic [STAGES-1:0] q,
  output logic              div_out
);

  localparam int RW = $clog2(2 * STAGES + 1);
  localparam int KW = $clog2(STAGES + 1);

  logic [RW-1:0] ratio;
  logic [KW-1:0] taps;
  logic          odd_ratio;
  logic          fb;
  logic          illegal;
  logic          tap_q;

  jdiv_ratio_decode #(.STAGES(STAGES), .SEL_W(SEL_W), .RW(RW), .KW(KW)) u_decode (
    .mod_sel (mod_sel),
    .ratio   (ratio),
    .taps    (taps),
    .odd     (odd_ratio)
  );

  jdiv_feedback #(.STAGES(STAGES), .KW(KW)) u_feedback (
    .q       (q),
    .taps    (taps),
    .odd     (odd_ratio),
    .fb      (fb),
    .illegal (illegal),
    .tap_q   (tap_q)
  );

  jdiv_ring #(.STAGES(STAGES)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .pre      (pre),
    .load_val (load_val),
    .fb       (fb),
    .q        (q)
  );

  assign div_out = tap_q;

endmodule

// File: rtl/jdiv_chk.sv
`timescale 1ns/1ps
module jdiv_chk #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4,
  parameter int RW     = 4,
  parameter int KW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              pre,
  input logic [STAGES-1:0] load_val,
  input logic [SEL_W-1:0]  mod_sel,
  input logic [STAGES-1:0] q,
  input logic              div_out,
  input logic [RW-1:0]     ratio,
  input logic [KW-1:0]     taps,
  input logic              odd,
  input logic              illegal
);

  logic [RW:0] stuck_cnt;

  always_ff @(posedge clk or posedge rst or posedge pre) begin
    if (rst || pre)   stuck_cnt <= '0;
    else if (illegal) stuck_cnt <= stuck_cnt + 1'b1;
    else              stuck_cnt <= '0;
  end

  AST_RESET_ONES: assert property (@(negedge clk) rst |-> (q == '1 && div_out)); // R1
  AST_PRESET_INVERTED: assert property (@(negedge clk) (pre && !rst) |-> q == ~load_val); // R2
  AST_RESET_WINS: assert property (@(negedge clk) (rst && pre) |-> q == '1); // R3
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (rst || pre)
    1'b1 |=> q[STAGES-1:1] == $past(q[STAGES-2:0])); // R4
  AST_EVEN_TAP: assert property (@(posedge clk) disable iff (rst || pre)
    (!odd && !illegal) |=> q[0] == ~$past(q[taps - 1'b1])); // R5
  AST_ODD_TAP: assert property (@(posedge clk) disable iff (rst || pre)
    (odd && !illegal) |=> q[0] == ~$past(q[taps - 1'b1] & q[taps - 2'd2])); // R6
  AST_RATIO_CLAMP: assert property (@(negedge clk)
    (mod_sel < SEL_W'(2) || mod_sel > SEL_W'(2 * STAGES)) |-> ratio == RW'(2 * STAGES)); // R7
  AST_DIV_TAP: assert property (@(negedge clk) div_out == q[taps - 1'b1]); // R8
  AST_ANTILOCK_SEED: assert property (@(posedge clk) disable iff (rst || pre)
    illegal |=> q[0]); // R9
  AST_LOCK_ESCAPE: assert property (@(posedge clk) disable iff (rst || pre)
    stuck_cnt <= (RW+1)'(ratio)); // R9

endmodule

bind johnson_div_n jdiv_chk #(.STAGES(STAGES), .SEL_W(SEL_W), .RW(RW), .KW(KW)) u_jdiv_chk (
  .clk      (clk),
  .rst      (rst),
  .pre      (pre),
  .load_val (load_val),
  .mod_sel  (mod_sel),
  .q        (q),
  .div_out  (div_out),
  .ratio    (ratio),
  .taps     (taps),
  .odd      (odd_ratio),
  .illegal  (illegal)
);

// File: tb/johnson_div_n_bench.sv
`timescale 1ns/1ps
module johnson_div_n_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pre = 1'b0;
  logic [4:0] load_val = '0;
  logic [3:0] mod_sel = 4'd10;
  logic [4:0] q;
  logic       div_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  johnson_div_n u_johnson_div_n (
    .clk(clk), .rst(rst), .pre(pre), .load_val(load_val),
    .mod_sel(mod_sel), .q(q), .div_out(div_out)
  );

  function automatic int exp_ratio(int sel);
    if (sel >= 2 && sel <= 10) return sel;
    return 10;
  endfunction

  // Window must be a run of ones anchored at either end of the active stages
  function automatic bit exp_legal(logic [4:0] v, int n);
    int k, mask, w, low;
    bit hit;
    k    = (n + 1) / 2;
    mask = (1 << k) - 1;
    w    = int'(v) & mask;
    hit  = 1'b0;
    for (int j = 0; j <= k; j++) begin
      low = (1 << j) - 1;
      if (w == low || w == (mask & ~low)) hit = 1'b1;
    end
    if ((n % 2) == 1 && w == 0) hit = 1'b0;
    return hit;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk(q == 5'h1f && div_out, "R1 reset forces ones", int'({div_out, q}), 63);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Per-clock: window in sequence and stages shift along (R4, R9)
  task automatic run_legal(int n, int cycles);
    logic [4:0] prev;
    prev = q;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(q[4:1] == prev[3:0], "R4 shift chain", int'(q[4:1]), int'(prev[3:0]));
      chk(exp_legal(q, n), "R9 window in sequence", int'(q), n);
      prev = q;
    end
  endtask

  task automatic measure(int n, string req);
    logic p;
    int   guard, cnt, low;
    bit   found;
    p = div_out; found = 1'b0; guard = 0;
    while (!found && guard < 3 * n + 2) begin
      @(negedge clk);
      guard++;
      if (!p && div_out) found = 1'b1;
      p = div_out;
    end
    chk(found, {req, " div_out rises"}, int'(found), 1);
    cnt = 0; low = 0; found = 1'b0;
    while (!found && cnt < 3 * n + 2) begin
      @(negedge clk);
      cnt++;
      if (!div_out) low++;
      if (!p && div_out) found = 1'b1;
      p = div_out;
    end
    chk(cnt == n, {req, " period"}, cnt, n);
    chk(low == n / 2, {req, " low time"}, low, n / 2);
  endtask

  // Preset a pattern, release, then watch the ring recover (R2, R9)
  task automatic recover(int sel, logic [4:0] lv);
    int n, waited;
    n = exp_ratio(sel);
    mod_sel = 4'(sel);
    @(negedge clk);
    #1;
    load_val = lv;
    pre = 1'b1;
    #0.5;
    chk(q == ~lv, "R2 preset loads inverse", int'(q), int'(~lv));
    @(negedge clk);
    pre = 1'b0;
    @(negedge clk);
    if (!exp_legal(~lv, n))
      chk(q[0] == 1'b1, "R9 guard seeds one", int'(q[0]), 1);
    waited = 1;
    while (!exp_legal(q, n) && waited <= n) begin
      @(negedge clk);
      waited++;
    end
    chk(waited <= n, "R9 recovery within N clocks", waited, n);
    run_legal(n, n + 2);
    measure(n, (n % 2 == 0) ? "R5" : "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int sels [5] = '{0, 1, 11, 12, 15};
    void'($urandom(32'h1f3a5));
    repeat (3) @(negedge clk);
    chk(q == 5'h1f && div_out, "R1 reset state", int'({div_out, q}), 63);
    @(negedge clk);
    rst = 1'b0;

    // Every ratio from a clean reset
    for (int n = 2; n <= 10; n++) begin
      mod_sel = 4'(n);
      do_reset();
      run_legal(n, 2 * n);
      measure(n, (n % 2 == 0) ? "R5 even ratio" : "R6 odd ratio");
      chk(div_out == q[(n + 1) / 2 - 1], "R8 div_out tap", int'(div_out), int'(q[(n + 1) / 2 - 1]));
    end

    // Out-of-range select codes
    foreach (sels[i]) begin
      mod_sel = 4'(sels[i]);
      do_reset();
      measure(10, "R7 clamp to 10");
    end

    // Reset and preset in the middle of a count
    mod_sel = 4'd7;
    do_reset();
    repeat (5) @(negedge clk);
    #1;
    load_val = 5'b10110;
    pre = 1'b1;
    #0.5;
    chk(q == 5'b01001, "R2 mid-count preset", int'(q), 9);
    rst = 1'b1;
    #0.5;
    chk(q == 5'h1f, "R3 reset over preset", int'(q), 31);
    @(negedge clk);
    chk(q == 5'h1f, "R3 held through edge", int'(q), 31);
    rst = 1'b0;
    pre = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b1;
    #0.5;
    chk(q == 5'h1f && div_out, "R1 mid-count reset", int'({div_out, q}), 63);
    @(negedge clk);
    rst = 1'b0;
    measure(7, "R6 after mid reset");

    // Directed out-of-sequence patterns
    recover(10, 5'b10101);
    recover(9,  5'b11001);
    recover(7,  5'b11010);
    recover(5,  5'b11010);
    recover(3,  5'b11100);
    recover(8,  5'b00000);

    // Seeded random select codes and load values
    for (int it = 0; it < 24; it++) begin
      recover(int'($urandom_range(0, 15)), 5'($urandom));
    end

    summary();
    $finish;
  end

endmodule